// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Walker

The walker moves a device-side buffer to or from host memory by following a table of segment descriptors kept in memory. A start pulse loads the table pointer from the programmed base and clears any segment left over from an earlier run. The engine then alternates between fetching a descriptor and issuing data bursts over a request/grant memory port, until the number of bytes the device asked for has moved or the table runs out. For each burst it presents the host address, the byte count, the direction and the byte offset into the local buffer. The data itself flows outside the block.

A run ends in one of two ways. `done` pulses when the device's byte count is used up. Any unused part of the current segment and the table position are then kept, so a later `cont` pulse can carry on from that point with a fresh byte count. `exhausted` pulses when a new segment is needed but none may be fetched. That happens when the last segment carried the end flag, or when the pointer is already a full page (PAGE bytes) past the table base, which guards against a table with no end flag. The controller has four named states: IDLE, CHECK, FETCH and BURST. IDLE goes to CHECK on start or cont. CHECK goes to IDLE on an outcome, to FETCH when the segment is empty, and to BURST otherwise. FETCH and BURST each return to CHECK on grant.

Top module: `sg_dma_walker`

## Requirements
- R1: A descriptor is fetched as one 8-byte read (mem_desc=1, mem_we=0, mem_len=8) at the current pointer. In mem_rdata, bits 31:0 are the segment address, bits 47:32 the count and bit 63 the end flag. The pointer then advances by 8.
- R2: Count bit 0 is ignored, and a count that ends up zero means 65536 bytes.
- R3: Each data burst moves min(bytes still needed, bytes left in segment, BURST_MAX), and that amount is never zero. The segment address and loc_idx then advance by the burst length, so no burst crosses a segment end.
- R4: Data bursts carry mem_we equal to the dir_to_mem value latched at start/cont (1 = buffer to memory, 0 = memory to buffer).
- R5: When a segment is used up and it carried the end flag while bytes are still needed, exhausted pulses for one cycle, no further fetch is issued, and done does not pulse.
- R6: When a segment is used up and the pointer is PAGE or more bytes past the table base, exhausted pulses without a further fetch.
- R7: done pulses once the needed bytes have moved. The segment state is kept, and a cont pulse resumes inside the same segment with a new byte count and loc_idx restarting at 0.
- R8: start reloads the pointer from tbl_base and discards any partly used segment, so the first request after start is a descriptor fetch at tbl_base.
- R9: busy is high from the cycle after start/cont until the cycle after the single done or exhausted pulse. start and cont are ignored while busy.
- R10: A request holds mem_addr, mem_len and mem_desc stable until mem_gnt.
- R11: Synchronous reset returns the engine to IDLE with busy, mem_req, done and exhausted low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin new transfer from table base |
| cont | input | 1 | Continue with kept segment state |
| tbl_base | input | 32 | Descriptor table base address |
| xfer_len | input | XW | Bytes the device needs for this run |
| dir_to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| mem_req | output | 1 | Memory request |
| mem_gnt | input | 1 | Grant; completes the request this cycle |
| mem_we | output | 1 | Write to memory |
| mem_desc | output | 1 | Request is a descriptor fetch |
| mem_addr | output | 32 | Host byte address |
| mem_len | output | BLW | Bytes in this request |
| mem_rdata | input | 64 | Descriptor word, valid with grant |
| loc_idx | output | XW | Local buffer byte offset of the burst |
| busy | output | 1 | Run in progress |
| done | output | 1 | Device count satisfied (pulse) |
| exhausted | output | 1 | Table ended first (pulse) |

## Verification
A wrong segment count or address shows up on the very next burst as a wrong mem_addr or mem_len. It shows up later as a run that ends with the wrong outcome or the wrong total byte count. A stale pointer or end flag appears at the next descriptor fetch, as a wrong address or as a fetch that should not occur. Errors in the kept state appear only after a later cont or start, so the directed scenarios chain runs back to back and compare every logged request.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_BURST
    } sg_state_e;

    localparam int SEG_CW = 17;

    typedef struct packed {
        logic [31:0]       addr;
        logic [SEG_CW-1:0] count;
        logic              last;
    } seg_desc_t;
endpackage

// File: rtl/sg_desc_decode.sv
module sg_desc_decode
    import sg_dma_pkg::*;
(
    input  logic [63:0] word,
    output seg_desc_t   desc
);
    logic [15:0] raw_even;

    always_comb begin
        raw_even   = word[47:32] & 16'hFFFE;
        desc.addr  = word[31:0];
        desc.last  = word[63];
        desc.count = (raw_even == 16'h0) ? SEG_CW'(17'h10000) : {1'b0, raw_even};
    end
endmodule

// File: rtl/sg_burst_len.sv
module sg_burst_len #(
    parameter int XW        = 20,
    parameter int BURST_MAX = 16,
    parameter int BLW       = 5
) (
    input  logic [XW-1:0]                 need,
    input  logic [sg_dma_pkg::SEG_CW-1:0] seg_left,
    output logic [BLW-1:0]                len
);
    int unsigned a, b, m;

    always_comb begin
        a = 32'(need);
        b = 32'(seg_left);
        m = (a < b) ? a : b;
        if (m > 32'(BURST_MAX)) m = 32'(BURST_MAX);
        len = BLW'(m);
    end
endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker
    import sg_dma_pkg::*;
#(
    parameter int XW        = 20,
    parameter int BURST_MAX = 16,
    parameter int PAGE      = 4096,
    localparam int BLW      = $clog2(BURST_MAX) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           cont,
    input  logic [31:0]    tbl_base,
    input  logic [XW-1:0]  xfer_len,
    input  logic           dir_to_mem,
    output logic           mem_req,
    input  logic           mem_gnt,
    output logic           mem_we,
    output logic           mem_desc,
    output logic [31:0]    mem_addr,
    output logic [BLW-1:0] mem_len,
    input  logic [63:0]    mem_rdata,
    output logic [XW-1:0]  loc_idx,
    output logic           busy,
    output logic           done,
    output logic           exhausted
);
    sg_state_e state, state_nx;

    logic [31:0]       ptr_q, base_q, seg_addr_q;
    logic [SEG_CW-1:0] seg_cnt_q;
    logic              seg_last_q, dir_q;
    logic [XW-1:0]     need_q, loc_q;

    seg_desc_t      fetched;
    logic [BLW-1:0] blen;
    logic           table_end, seg_empty, need_zero;

    sg_desc_decode u_dec (
        .word (mem_rdata),
        .desc (fetched)
    );

    sg_burst_len #(
        .XW        (XW),
        .BURST_MAX (BURST_MAX),
        .BLW       (BLW)
    ) u_len (
        .need     (need_q),
        .seg_left (seg_cnt_q),
        .len      (blen)
    );

    assign seg_empty = (seg_cnt_q == '0);
    assign need_zero = (need_q == '0);
    assign table_end = seg_last_q || ((ptr_q - base_q) >= 32'(PAGE));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start || cont) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (need_zero)       state_nx = ST_IDLE;
                else if (!seg_empty) state_nx = ST_BURST;
                else if (table_end)  state_nx = ST_IDLE;
                else                 state_nx = ST_FETCH;
            end
            ST_FETCH: if (mem_gnt) state_nx = ST_CHECK;
            ST_BURST: if (mem_gnt) state_nx = ST_CHECK;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            base_q     <= '0;
            seg_addr_q <= '0;
            seg_cnt_q  <= '0;
            seg_last_q <= 1'b0;
            dir_q      <= 1'b0;
            need_q     <= '0;
            loc_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ptr_q      <= tbl_base;
                        base_q     <= tbl_base;
                        seg_addr_q <= '0;
                        seg_cnt_q  <= '0;
                        seg_last_q <= 1'b0;
                    end
                    if (start || cont) begin
                        need_q <= xfer_len;
                        loc_q  <= '0;
                        dir_q  <= dir_to_mem;
                    end
                end
                ST_FETCH: if (mem_gnt) begin
                    seg_addr_q <= fetched.addr;
                    seg_cnt_q  <= fetched.count;
                    seg_last_q <= fetched.last;
                    ptr_q      <= ptr_q + 32'd8;
                end
                ST_BURST: if (mem_gnt) begin
                    seg_addr_q <= seg_addr_q + 32'(blen);
                    seg_cnt_q  <= seg_cnt_q - SEG_CW'(blen);
                    need_q     <= need_q - XW'(blen);
                    loc_q      <= loc_q + XW'(blen);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_CHECK) && need_zero;
        exhausted = (state == ST_CHECK) && !need_zero && seg_empty && table_end;
        mem_req   = (state == ST_FETCH) || (state == ST_BURST);
        mem_desc  = (state == ST_FETCH);
        mem_we    = (state == ST_BURST) && dir_q;
        mem_addr  = (state == ST_FETCH) ? ptr_q : seg_addr_q;
        mem_len   = (state == ST_FETCH) ? BLW'(8) : blen;
        loc_idx   = loc_q;
    end
endmodule

// File: rtl/sg_dma_walker_chk.sv
module sg_dma_walker_chk #(
    parameter int BURST_MAX = 16,
    parameter int BLW       = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           cont,
    input logic           mem_req,
    input logic           mem_gnt,
    input logic           mem_we,
    input logic           mem_desc,
    input logic [31:0]    mem_addr,
    input logic [BLW-1:0] mem_len,
    input logic           busy,
    input logic           done,
    input logic           exhausted
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_desc)); // R10
    AST_BURST_SIZE: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_desc |-> (mem_len != '0) && (32'(mem_len) <= BURST_MAX)); // R3
    AST_DESC_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_desc |-> !mem_we && (mem_len == BLW'(8))); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(done && exhausted)); // R9
    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done || exhausted) |=> !busy); // R9
    AST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (start || cont) && !busy |=> busy); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req && !done && !exhausted); // R11
endmodule

bind sg_dma_walker sg_dma_walker_chk #(
    .BURST_MAX (BURST_MAX),
    .BLW       (BLW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cont      (cont),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_desc  (mem_desc),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .busy      (busy),
    .done      (done),
    .exhausted (exhausted)
);

// File: tb/sg_dma_walker_test.sv
module sg_dma_walker_test;
    localparam int XW  = 20;
    localparam int BLW = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0, cont = 1'b0, dir_to_mem = 1'b0;
    logic [31:0]    tbl_base = '0;
    logic [XW-1:0]  xfer_len = '0;
    logic           mem_req, mem_we, mem_desc, busy, done, exhausted;
    logic           mem_gnt = 1'b0;
    logic [31:0]    mem_addr;
    logic [BLW-1:0] mem_len;
    logic [63:0]    mem_rdata = '0;
    logic [XW-1:0]  loc_idx;

    always #2.5 clk = ~clk;

    sg_dma_walker #(.XW(XW)) uut (
        .clk(clk), .rst(rst), .start(start), .cont(cont), .tbl_base(tbl_base),
        .xfer_len(xfer_len), .dir_to_mem(dir_to_mem), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_desc(mem_desc),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_rdata(mem_rdata),
        .loc_idx(loc_idx), .busy(busy), .done(done), .exhausted(exhausted)
    );

    int checks = 0, errors = 0;

    // descriptor table model
    logic [63:0] table_w [0:15];
    logic [63:0] default_w = '0;
    logic [31:0] tb_base = '0;
    int          gnt_delay = 0, dly_cnt = 0;

    // transaction log
    int          n_tx = 0, n_fetch = 0, n_burst = 0, total = 0, n_done = 0, n_exh = 0;
    logic [31:0] lg_addr [0:63];
    int          lg_len  [0:63];
    logic        lg_desc [0:63];
    logic        lg_we   [0:63];
    int          lg_loc  [0:63];
    logic [31:0] last_addr = '0;
    logic        any_we_wrong = 1'b0;
    logic        exp_we = 1'b0;

    function automatic logic [63:0] desc_at(logic [31:0] a);
        int idx = int'((a - tb_base) >> 3);
        if (idx >= 0 && idx < 16) return table_w[idx];
        return default_w;
    endfunction

    function automatic logic [63:0] mk(logic [31:0] a, logic [15:0] c, logic last);
        return {last, 15'b0, c, a};
    endfunction

    always @(negedge clk) begin
        if (done) n_done++;
        if (exhausted) n_exh++;
        if (mem_gnt) begin
            mem_gnt = 1'b0;
        end else if (mem_req && !rst) begin
            if (dly_cnt >= gnt_delay) begin
                dly_cnt = 0;
                mem_gnt = 1'b1;
                if (mem_desc) begin
                    mem_rdata = desc_at(mem_addr);
                    n_fetch++;
                end else begin
                    n_burst++;
                    total += int'(mem_len);
                    last_addr = mem_addr;
                    if (mem_we !== exp_we) any_we_wrong = 1'b1;
                end
                if (n_tx < 64) begin
                    lg_addr[n_tx] = mem_addr;
                    lg_len[n_tx]  = int'(mem_len);
                    lg_desc[n_tx] = mem_desc;
                    lg_we[n_tx]   = mem_we;
                    lg_loc[n_tx]  = int'(loc_idx);
                end
                n_tx++;
            end else begin
                dly_cnt++;
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_tx = 0; n_fetch = 0; n_burst = 0; total = 0; n_done = 0; n_exh = 0;
        any_we_wrong = 1'b0;
    endtask

    task automatic pulse(logic s, logic c, logic [31:0] base, int len, logic dir);
        @(negedge clk);
        tbl_base = base; xfer_len = XW'(len); dir_to_mem = dir;
        start = s; cont = c;
        @(negedge clk);
        start = 1'b0; cont = 1'b0;
    endtask

    task automatic wait_end();
        int guard = 0;
        while ((n_done + n_exh) == 0 && guard < 100000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic exp_tx(string tag, int i, logic d, logic [31:0] a, int l, int loc);
        chk({tag, " desc flag"}, lg_desc[i], d);
        chk({tag, " addr"}, lg_addr[i], a);
        chk({tag, " len"}, lg_len[i], l);
        if (!d) chk({tag, " loc_idx"}, lg_loc[i], loc);
    endtask

    task automatic t_reset();
        chk("R11 busy after reset", busy, 0);
        chk("R11 mem_req after reset", mem_req, 0);
        chk("R11 outcome after reset", done | exhausted, 0);
    endtask

    task automatic t_single();
        tb_base = 32'h100; table_w[0] = mk(32'h1000, 16'd40, 1'b1);
        gnt_delay = 0; exp_we = 1'b1; clear_log();
        pulse(1, 0, 32'h100, 40, 1);
        chk("R9 busy after start", busy, 1);
        wait_end();
        chk("R7 done count", n_done, 1);
        chk("R9 no exhausted", n_exh, 0);
        chk("R9 busy low after done", busy, 0);
        chk("R1 tx count", n_tx, 4);
        exp_tx("R1 fetch", 0, 1, 32'h100, 8, 0);
        exp_tx("R3 burst0", 1, 0, 32'h1000, 16, 0);
        exp_tx("R3 burst1", 2, 0, 32'h1010, 16, 16);
        exp_tx("R3 burst2", 3, 0, 32'h1020, 8, 32);
        chk("R4 write dir", any_we_wrong, 0);
        chk("R1 fetch is read", lg_we[0], 0);
    endtask

    task automatic t_multi_read();
        tb_base = 32'h200;
        table_w[0] = mk(32'h2000, 16'h0007, 1'b0);
        table_w[1] = mk(32'h3000, 16'h0021, 1'b1);
        gnt_delay = 2; exp_we = 1'b0; clear_log();
        pulse(1, 0, 32'h200, 38, 0);
        wait_end();
        chk("R2 done with odd counts", n_done, 1);
        chk("R1 tx count multi", n_tx, 5);
        exp_tx("R1 fetch0", 0, 1, 32'h200, 8, 0);
        exp_tx("R2 seg0 bit0 dropped", 1, 0, 32'h2000, 6, 0);
        exp_tx("R1 fetch1 ptr+8", 2, 1, 32'h208, 8, 0);
        exp_tx("R3 seg1 a", 3, 0, 32'h3000, 16, 6);
        exp_tx("R3 seg1 b", 4, 0, 32'h3010, 16, 22);
        chk("R4 read dir", any_we_wrong, 0);
    endtask

    task automatic t_eot();
        gnt_delay = 0; exp_we = 1'b0; clear_log();
        pulse(1, 0, 32'h200, 100, 0);
        wait_end();
        chk("R5 exhausted", n_exh, 1);
        chk("R5 no done", n_done, 0);
        chk("R5 bytes moved", total, 38);
        chk("R5 no fetch past end", n_fetch, 2);
        chk("R9 busy low after exhausted", busy, 0);
    endtask

    task automatic t_continue();
        tb_base = 32'h400; table_w[0] = mk(32'h4000, 16'd48, 1'b1);
        exp_we = 1'b1; clear_log();
        pulse(1, 0, 32'h400, 20, 1);
        wait_end();
        chk("R7 first done", n_done, 1);
        chk("R7 first total", total, 20);
        clear_log();
        pulse(0, 1, 32'h400, 28, 1);
        // R9: start while busy must be ignored
        pulse(1, 0, 32'h9000, 8, 0);
        wait_end();
        chk("R7 cont done", n_done, 1);
        chk("R7 cont no refetch", n_fetch, 0);
        chk("R7 cont tx count", n_tx, 2);
        exp_tx("R7 cont burst0", 0, 0, 32'h4014, 16, 0);
        exp_tx("R7 cont burst1", 1, 0, 32'h4024, 12, 16);
        chk("R9 start ignored dir", any_we_wrong, 0);
    endtask

    task automatic t_restart();
        tb_base = 32'h400; table_w[0] = mk(32'h4000, 16'd48, 1'b1);
        exp_we = 1'b0; clear_log();
        pulse(1, 0, 32'h400, 20, 0);
        wait_end();
        clear_log();
        pulse(1, 0, 32'h400, 8, 0);
        wait_end();
        chk("R8 restart tx count", n_tx, 2);
        exp_tx("R8 refetch at base", 0, 1, 32'h400, 8, 0);
        exp_tx("R8 segment from start", 1, 0, 32'h4000, 8, 0);
    endtask

    task automatic t_zero_count();
        tb_base = 32'h800; table_w[0] = mk(32'h10000, 16'h0001, 1'b1);
        exp_we = 1'b1; clear_log();
        pulse(1, 0, 32'h800, 70000, 1);
        wait_end();
        chk("R2 zero count exhausted", n_exh, 1);
        chk("R2 zero count = 64K", total, 65536);
        chk("R2 burst count", n_burst, 4096);
        chk("R3 last burst addr", last_addr, 32'h1FFF0);
    endtask

    task automatic t_failsafe();
        tb_base = 32'hA000;
        for (int i = 0; i < 16; i++) table_w[i] = mk(32'h8000, 16'h0003, 1'b0);
        default_w = mk(32'h8000, 16'h0003, 1'b0);
        exp_we = 1'b0; clear_log();
        pulse(1, 0, 32'hA000, 2000, 0);
        wait_end();
        chk("R6 fail-safe exhausted", n_exh, 1);
        chk("R6 fetches within page", n_fetch, 512);
        chk("R6 bytes moved", total, 1024);
    endtask

    task automatic t_mid_reset();
        tb_base = 32'h800; table_w[0] = mk(32'h10000, 16'h0000, 1'b1);
        clear_log();
        pulse(1, 0, 32'h800, 70000, 1);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 busy in reset", busy, 0);
        chk("R11 req in reset", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 idle after reset", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) table_w[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi_read();
        t_eot();
        t_continue();
        t_restart();
        t_zero_count();
        t_failsafe();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule